// File: doc/BRIEF.md
# Task Register Load and Store Unit

This unit holds the task register of a protected-mode processor. The register has two parts. The visible part is a 16-bit selector. The hidden part is the 32-bit base and the 20-bit limit of the current task state segment. Two requests act on it. A store request returns the visible selector. A load request checks the operating mode, the privilege level and the selector. It then reads the addressed 8-byte descriptor from the global descriptor table over a simple memory port and validates it. If the descriptor is valid, the unit caches its base and limit, writes the descriptor back with the busy flag set, and takes the new selector.

A load only marks the new segment busy and records where it is. It does not switch tasks and it changes no other state. Every request finishes with a single `done` pulse. When a check fails, the pulse carries one exception code. Before the first successful load the register contents have no meaning, and `trValid` stays low until that load.

The memory port returns read data one cycle after `memRdEn`. A load reads the low word of the descriptor and then the high word, in back-to-back cycles. Exception codes on `excCode`: 0 means no exception, 1 means invalid opcode, 2 means general protection, 3 means segment not present.

Top module: `taskreg_unit`

## Requirements
- R1: While reset is held and in the cycle after it is released, `done`, `excValid`, `memRdEn`, `memWrEn` and `trValid` are 0, and `storeSel` is 0.
- R2: With `protEn`=0, a load request or a store request ends with `excCode`=1. The selector, base, limit and valid flag stay unchanged, and no memory access is made.
- R3: With `protEn`=1, a store request at any `cpl` ends with `excCode`=0 and returns the current visible selector on `storeSel`.
- R4: A load request with `cpl` not 0 ends with `excCode`=2 and makes no memory access.
- R5: A load request whose selector bit 2 is 1 ends with `excCode`=2 and makes no memory access.
- R6: A load that passes R2, R4 and R5 makes exactly two reads. The first read is at `gdtBase + loadSel[15:3]*8` and the second is at that address + 4, in the next cycle.
- R7: The descriptor high word must have bit 12 equal to 0 and bits 11:8 equal to 4'b1001 (available) or 4'b1011 (busy). Otherwise the load ends with `excCode`=2. A descriptor that is already busy (type bit 9 = 1) also ends with `excCode`=2.
- R8: A descriptor with present bit 15 of the high word equal to 0 ends the load with `excCode`=3. The R7 checks take precedence over this one.
- R9: A load that passes every check has the following effects:
  - base = {hi[31:24], hi[7:0], lo[31:16]} and limit = {hi[19:16], lo[15:0]};
  - the high word is written once, with bit 9 set, to descriptor address + 4;
  - `storeSel` takes the full loaded selector and `trValid` becomes 1;
  - the load ends with `excCode`=0.
- R10: A faulting request produces exactly one one-cycle `done` pulse, makes no memory write and leaves the register unchanged. `excValid` is high only together with `done`.
- R11: When several checks fail, the reported code follows this order: mode, then privilege, then table indicator, then descriptor type and busy, then present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadReq | input | 1 | Load request, one cycle, taken while idle |
| storeReq | input | 1 | Store request, one cycle, taken while idle |
| protEn | input | 1 | Protected mode enabled |
| cpl | input | 2 | Current privilege level |
| loadSel | input | 16 | Selector to load |
| gdtBase | input | ADDR_W | Global descriptor table base address |
| memRdEn | output | 1 | Memory read strobe |
| memWrEn | output | 1 | Memory write strobe |
| memAddr | output | ADDR_W | Memory word address (byte units) |
| memWrData | output | 32 | Memory write data |
| memRdData | input | 32 | Read data, valid the cycle after memRdEn |
| done | output | 1 | Request finished, one-cycle pulse |
| excValid | output | 1 | An exception is reported with done |
| excCode | output | 2 | Exception code |
| storeSel | output | 16 | Visible selector |
| trValid | output | 1 | Register loaded at least once since reset |
| trBase | output | 32 | Cached segment base |
| trLimit | output | 20 | Cached segment limit |

## Verification
The assertions rely on two things. First, read data comes back exactly one cycle after a read strobe. Second, a new request is raised only while the unit is idle, and a single request never has both load and store raised. The stimulus keeps to this. It raises one request for a single cycle, waits until the scoreboard has taken the matching `done`, and only then issues the next request. The bench memory is a registered array that answers each read in the next cycle. `gdtBase` is held constant throughout the run.

// File: rtl/taskreg_pkg.sv
package taskreg_pkg;
  localparam int SEL_W   = 16;
  localparam int WORD_W  = 32;
  localparam int LIMIT_W = 20;
  localparam int BUSY_BIT = 9;
  localparam int HI_OFFSET = 4;

  typedef enum logic [1:0] {
    EXC_NONE = 2'd0,
    EXC_UD   = 2'd1,
    EXC_GP   = 2'd2,
    EXC_NP   = 2'd3
  } excCode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDLO,
    ST_RDHI,
    ST_EVAL,
    ST_WRITE,
    ST_FIN
  } state_e;

  typedef struct packed {
    logic latchReq;
    logic rdEn;
    logic hiWord;
    logic latchLo;
    logic latchHi;
    logic wrEn;
    logic loadTr;
  } strobe_t;
endpackage

// File: rtl/taskreg_ctrl.sv
module taskreg_ctrl
  import taskreg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadReq,
  input  logic       storeReq,
  input  logic       protEn,
  input  logic [1:0] cpl,
  input  logic       selTi,
  input  logic [3:0] descType,
  input  logic       descS,
  input  logic       descP,
  output strobe_t    strobe,
  output logic       done,
  output excCode_e   excCode
);
  state_e   stateQ, stateD;
  excCode_e excQ, excD;
  logic     typeIsTss;

  // 10x1: a task segment descriptor, bit 1 of the type being the busy flag
  assign typeIsTss = !descS && descType[3] && !descType[2] && descType[0];

  always_comb begin
    stateD = stateQ;
    excD   = excQ;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (loadReq) begin
          strobe.latchReq = 1'b1;
          stateD = ST_FIN;
          if (!protEn)          excD = EXC_UD;
          else if (cpl != 2'd0) excD = EXC_GP;
          else if (selTi)       excD = EXC_GP;
          else begin
            excD   = EXC_NONE;
            stateD = ST_RDLO;
          end
        end else if (storeReq) begin
          stateD = ST_FIN;
          excD   = protEn ? EXC_NONE : EXC_UD;
        end
      end
      ST_RDLO: begin
        strobe.rdEn = 1'b1;
        stateD = ST_RDHI;
      end
      ST_RDHI: begin
        strobe.rdEn    = 1'b1;
        strobe.hiWord  = 1'b1;
        strobe.latchLo = 1'b1;
        stateD = ST_EVAL;
      end
      ST_EVAL: begin
        strobe.latchHi = 1'b1;
        stateD = ST_FIN;
        if (!typeIsTss)       excD = EXC_GP;
        else if (descType[1]) excD = EXC_GP;
        else if (!descP)      excD = EXC_NP;
        else                  stateD = ST_WRITE;
      end
      ST_WRITE: begin
        strobe.wrEn   = 1'b1;
        strobe.hiWord = 1'b1;
        strobe.loadTr = 1'b1;
        stateD = ST_FIN;
      end
      ST_FIN: begin
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      excQ   <= EXC_NONE;
    end else begin
      stateQ <= stateD;
      excQ   <= excD;
    end
  end

  assign done    = (stateQ == ST_FIN);
  assign excCode = done ? excQ : EXC_NONE;
endmodule

// File: rtl/taskreg_dp.sv
module taskreg_dp
  import taskreg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobe,
  input  logic [SEL_W-1:0]    loadSel,
  input  logic [ADDR_W-1:0]   gdtBase,
  input  logic [WORD_W-1:0]   memRdData,
  output logic                memRdEn,
  output logic                memWrEn,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [WORD_W-1:0]   memWrData,
  output logic [3:0]          descType,
  output logic                descS,
  output logic                descP,
  output logic [SEL_W-1:0]    storeSel,
  output logic                trValid,
  output logic [WORD_W-1:0]   trBase,
  output logic [LIMIT_W-1:0]  trLimit
);
  localparam int IDX_W = SEL_W - 3;

  logic [SEL_W-1:0]   reqSelQ;
  logic [WORD_W-1:0]  loQ, hiQ;
  logic [ADDR_W-1:0]  descAddr;
  logic [SEL_W-1:0]   selQ;
  logic               validQ;
  logic [WORD_W-1:0]  baseQ;
  logic [LIMIT_W-1:0] limitQ;

  assign descAddr  = gdtBase + {{(ADDR_W-IDX_W-3){1'b0}}, reqSelQ[SEL_W-1:3], 3'b000};
  assign memAddr   = descAddr + (strobe.hiWord ? ADDR_W'(HI_OFFSET) : '0);
  assign memRdEn   = strobe.rdEn;
  assign memWrEn   = strobe.wrEn;
  assign memWrData = hiQ | (WORD_W'(1) << BUSY_BIT);

  assign descType = memRdData[11:8];
  assign descS    = memRdData[12];
  assign descP    = memRdData[15];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqSelQ <= '0;
      loQ     <= '0;
      hiQ     <= '0;
    end else begin
      if (strobe.latchReq) reqSelQ <= loadSel;
      if (strobe.latchLo)  loQ     <= memRdData;
      if (strobe.latchHi)  hiQ     <= memRdData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ   <= '0;
      validQ <= 1'b0;
      baseQ  <= '0;
      limitQ <= '0;
    end else if (strobe.loadTr) begin
      selQ   <= reqSelQ;
      validQ <= 1'b1;
      baseQ  <= {hiQ[31:24], hiQ[7:0], loQ[31:16]};
      limitQ <= {hiQ[19:16], loQ[15:0]};
    end
  end

  assign storeSel = selQ;
  assign trValid  = validQ;
  assign trBase   = baseQ;
  assign trLimit  = limitQ;
endmodule

// File: rtl/taskreg_unit.sv
module taskreg_unit
  import taskreg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadReq,
  input  logic              storeReq,
  input  logic              protEn,
  input  logic [1:0]        cpl,
  input  logic [15:0]       loadSel,
  input  logic [ADDR_W-1:0] gdtBase,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWrData,
  input  logic [31:0]       memRdData,
  output logic              done,
  output logic              excValid,
  output logic [1:0]        excCode,
  output logic [15:0]       storeSel,
  output logic              trValid,
  output logic [31:0]       trBase,
  output logic [19:0]       trLimit
);
  strobe_t  strobe;
  excCode_e exc;
  logic [3:0] descType;
  logic descS, descP;

  taskreg_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .loadReq  (loadReq),
    .storeReq (storeReq),
    .protEn   (protEn),
    .cpl      (cpl),
    .selTi    (loadSel[2]),
    .descType (descType),
    .descS    (descS),
    .descP    (descP),
    .strobe   (strobe),
    .done     (done),
    .excCode  (exc)
  );

  taskreg_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .loadSel   (loadSel),
    .gdtBase   (gdtBase),
    .memRdData (memRdData),
    .memRdEn   (memRdEn),
    .memWrEn   (memWrEn),
    .memAddr   (memAddr),
    .memWrData (memWrData),
    .descType  (descType),
    .descS     (descS),
    .descP     (descP),
    .storeSel  (storeSel),
    .trValid   (trValid),
    .trBase    (trBase),
    .trLimit   (trLimit)
  );

  assign excCode  = exc;
  assign excValid = (exc != EXC_NONE);
endmodule

// File: rtl/taskreg_chk.sv
module taskreg_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              memRdEn,
  input logic              memWrEn,
  input logic [ADDR_W-1:0] memAddr,
  input logic              done,
  input logic              excValid,
  input logic              trValid
);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_exc_with_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> done);

  assert_write_then_success_R10: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> (done && !excValid));

  assert_read_pair_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memRdEn) |=> (memRdEn && memAddr == $past(memAddr) + ADDR_W'(4)));

  assert_write_addr_R9: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> ($past(memRdEn, 2) && memAddr == $past(memAddr, 2)));

  assert_valid_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    trValid |=> trValid);

  assert_valid_after_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trValid) |-> $past(memWrEn));
endmodule

bind taskreg_unit taskreg_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .memRdEn  (memRdEn),
  .memWrEn  (memWrEn),
  .memAddr  (memAddr),
  .done     (done),
  .excValid (excValid),
  .trValid  (trValid)
);

// File: tb/tb_taskreg_unit.sv
module tb_taskreg_unit;
  localparam logic [31:0] GDT = 32'h0000_0100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadReq = 1'b0, storeReq = 1'b0, protEn = 1'b1;
  logic [1:0] cpl = 2'd0;
  logic [15:0] loadSel = '0;
  logic [31:0] gdtBase = GDT;
  logic memRdEn, memWrEn;
  logic [31:0] memAddr, memWrData, memRdData;
  logic done, excValid, trValid;
  logic [1:0] excCode;
  logic [15:0] storeSel;
  logic [31:0] trBase;
  logic [19:0] trLimit;

  always #2.5 clk = ~clk;

  taskreg_unit dut (
    .clk(clk), .rstN(rstN), .loadReq(loadReq), .storeReq(storeReq),
    .protEn(protEn), .cpl(cpl), .loadSel(loadSel), .gdtBase(gdtBase),
    .memRdEn(memRdEn), .memWrEn(memWrEn), .memAddr(memAddr),
    .memWrData(memWrData), .memRdData(memRdData), .done(done),
    .excValid(excValid), .excCode(excCode), .storeSel(storeSel),
    .trValid(trValid), .trBase(trBase), .trLimit(trLimit)
  );

  // memory model: read data one cycle after the strobe
  logic [31:0] mem [0:63];
  int rdCount, wrCount;
  logic [31:0] rdAddr0, rdAddr1, wrAddr;

  function automatic int widx(logic [31:0] a);
    return int'(((a - GDT) >> 2) & 32'd63);
  endfunction

  always @(posedge clk) begin
    if (memRdEn) begin
      memRdData <= mem[widx(memAddr)];
      if (rdCount == 0) rdAddr0 = memAddr;
      if (rdCount == 1) rdAddr1 = memAddr;
      rdCount = rdCount + 1;
    end
    if (memWrEn) begin
      mem[widx(memAddr)] <= memWrData;
      wrAddr = memAddr;
      wrCount = wrCount + 1;
    end
  end

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct {
    string       req;
    bit          isStore;
    logic [1:0]  code;
    logic [15:0] sel;
    logic        valid;
    logic [31:0] base;
    logic [19:0] limit;
    int          nRd;
    int          nWr;
    logic [31:0] addr;
  } item_t;

  item_t sb[$];

  // model of the register
  logic [15:0] mSel = '0;
  logic        mValid = 1'b0;
  logic [31:0] mBase = '0;
  logic [19:0] mLimit = '0;

  function automatic logic [31:0] mkHi(logic [31:0] b, logic [19:0] l,
                                       logic [3:0] t, logic s, logic p);
    return {b[31:24], 4'b0100, l[19:16], p, 2'b00, s, t, b[23:16]};
  endfunction

  task automatic putDesc(int idx, logic [31:0] b, logic [19:0] l,
                         logic [3:0] t, logic s, logic p);
    mem[idx*2]   = {b[15:0], l[15:0]};
    mem[idx*2+1] = mkHi(b, l, t, s, p);
  endtask

  task automatic runOp(string req, bit isLoad, bit pe, logic [1:0] c, logic [15:0] sel);
    item_t it;
    logic [31:0] lo, hi;
    it.req = req; it.isStore = !isLoad; it.nRd = 0; it.nWr = 0;
    it.addr = GDT + {16'h0, sel[15:3], 3'b000};
    if (!pe) it.code = 2'd1;
    else if (!isLoad) it.code = 2'd0;
    else if (c != 2'd0) it.code = 2'd2;
    else if (sel[2]) it.code = 2'd2;
    else begin
      it.nRd = 2;
      lo = mem[widx(it.addr)];
      hi = mem[widx(it.addr) + 1];
      if (hi[12] || hi[11:8] != 4'b1001 && hi[11:8] != 4'b1011) it.code = 2'd2;
      else if (hi[9]) it.code = 2'd2;
      else if (!hi[15]) it.code = 2'd3;
      else begin
        it.code = 2'd0; it.nWr = 1;
        mSel = sel; mValid = 1'b1;
        mBase = {hi[31:24], hi[7:0], lo[31:16]};
        mLimit = {hi[19:16], lo[15:0]};
      end
    end
    it.sel = mSel; it.valid = mValid; it.base = mBase; it.limit = mLimit;
    @(negedge clk);
    rdCount = 0; wrCount = 0;
    sb.push_back(it);
    protEn = pe; cpl = c; loadSel = sel;
    loadReq = isLoad; storeReq = !isLoad;
    @(negedge clk);
    loadReq = 1'b0; storeReq = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN && done) begin
      if (sb.size() == 0) chk("R10 unexpected done", 32'd1, 32'd0);
      else begin
        item_t e;
        e = sb.pop_front();
        chk({e.req, " code"}, {30'h0, excCode}, {30'h0, e.code});
        chk({e.req, " excValid"}, {31'h0, excValid}, {31'h0, e.code != 2'd0});
        chk({e.req, " sel"}, {16'h0, storeSel}, {16'h0, e.sel});
        chk({e.req, " valid"}, {31'h0, trValid}, {31'h0, e.valid});
        chk({e.req, " base"}, trBase, e.base);
        chk({e.req, " limit"}, {12'h0, trLimit}, {12'h0, e.limit});
        chk({e.req, " reads"}, rdCount, e.nRd);
        chk({e.req, " writes"}, wrCount, e.nWr);
        if (e.nRd == 2) begin
          chk("R6 first read addr", rdAddr0, e.addr);
          chk("R6 second read addr", rdAddr1, e.addr + 32'd4);
        end
        if (e.nWr == 1) begin
          chk("R9 write addr", wrAddr, e.addr + 32'd4);
          chk("R9 busy set", {31'h0, mem[widx(e.addr) + 1][9]}, 32'd1);
        end
      end
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    rdCount = 0; wrCount = 0; memRdData = '0;
    rdAddr0 = '0; rdAddr1 = '0; wrAddr = '0;
    putDesc(2, 32'h0, 20'hFFFFF, 4'b1010, 1'b1, 1'b1);
    putDesc(3, 32'h1234_5678, 20'h00067, 4'b1001, 1'b0, 1'b1);
    putDesc(4, 32'h0, 20'h00067, 4'b1001, 1'b1, 1'b1);
    putDesc(6, 32'h0, 20'h00067, 4'b1011, 1'b0, 1'b1);
    putDesc(7, 32'h0, 20'h00067, 4'b1001, 1'b0, 1'b0);
    putDesc(8, 32'h0, 20'h00067, 4'b1011, 1'b0, 1'b0);
    putDesc(9, 32'h0, 20'h00067, 4'b0010, 1'b0, 1'b1);
    putDesc(31, 32'hA0B0_C0D0, 20'hF1234, 4'b1001, 1'b0, 1'b1);

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 done", {31'h0, done}, 32'd0);
    chk("R1 memRdEn", {31'h0, memRdEn}, 32'd0);
    chk("R1 trValid", {31'h0, trValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release done", {31'h0, done}, 32'd0);
    chk("R1 after release memWrEn", {31'h0, memWrEn}, 32'd0);
    chk("R1 after release excValid", {31'h0, excValid}, 32'd0);
    chk("R1 storeSel", {16'h0, storeSel}, 32'd0);

    runOp("R3 store before load", 0, 1, 2'd3, 16'h0);
    runOp("R2 load in real mode", 1, 0, 2'd0, 16'h0018);
    runOp("R2 store in real mode", 0, 0, 2'd0, 16'h0);
    runOp("R4 load cpl1", 1, 1, 2'd1, 16'h0018);
    runOp("R4 load cpl3", 1, 1, 2'd3, 16'h0018);
    runOp("R5 local table", 1, 1, 2'd0, 16'h001C);
    runOp("R11 mode over priv and TI", 1, 0, 2'd2, 16'h001C);
    runOp("R11 priv over TI", 1, 1, 2'd3, 16'h001C);
    runOp("R7 code segment", 1, 1, 2'd0, 16'h0010);
    runOp("R7 S bit set", 1, 1, 2'd0, 16'h0020);
    runOp("R7 system type not task", 1, 1, 2'd0, 16'h0048);
    runOp("R7 empty entry", 1, 1, 2'd0, 16'h0000);
    runOp("R7 already busy", 1, 1, 2'd0, 16'h0030);
    runOp("R8 not present", 1, 1, 2'd0, 16'h0038);
    runOp("R11 busy over not present", 1, 1, 2'd0, 16'h0040);
    runOp("R9 first load", 1, 1, 2'd0, 16'h0018);
    runOp("R3 store cpl3", 0, 1, 2'd3, 16'h0);
    runOp("R10 reload now busy", 1, 1, 2'd0, 16'h0018);
    runOp("R9 load top index", 1, 1, 2'd0, 16'h00FB);
    runOp("R3 store cpl0", 0, 1, 2'd0, 16'h0);
    runOp("R2 real mode keeps register", 1, 0, 2'd0, 16'h0018);
    runOp("R3 store after fault", 0, 1, 2'd1, 16'h0);
    finish();
  end
endmodule